// File: doc/BRIEF.md
# Free-Running Compare Timer

A memory-mapped general-purpose timer built around a free-running up-counter. Software picks a count source, a divide ratio and two compare values through a small 32-bit register bus. Each compare channel raises a sticky status flag when the counter steps onto its value. An interrupt line is driven from the flags that software has enabled. The counter is never stopped or reloaded by a match, so one timer can serve as a time base and as an event source at once.

The block runs on one clock. The choice of count source is modelled as a per-cycle tick: every cycle, one of two external tick strobes, or nothing at all. A low-power input, qualified by a mode code, stalls the counter unless the control register allows counting in that mode. A self-clearing software reset bit in the control register returns the block to a known state. That reset keeps the source selection and the low-power run permissions.

Register map (word index on `bus_addr`). 0 = control. 1 = divider. 2 = flags (write one to clear). 3 = interrupt enables. 4 = compare A. 5 = compare B. 6 = count (read-only). Control layout: bit 0 run enable; bits 2:1 source (0 none, 1 every clock, 2 `tick_slow`, 3 `tick_ref`); bits 7:4 low-power run permissions (bit 4 stop, 5 doze, 6 wait, 7 debug); bit 15 software reset. Flag and enable bit 0 belong to compare A and bit 1 to compare B. Reads return the register value zero-extended.

Top module: `ftmr_top`

## Requirements
- R1: The count register advances by exactly one per divided step and wraps from all ones to zero without stopping.
- R2: With divider value d, the count advances once every d+1 selected source ticks, so d = 0 counts every tick. Writing the divider restarts the division phase.
- R3: Writing control with bit 15 set starts a software reset. Bit 15 reads 1 for exactly 4 cycles and then 0. Source bits 2:1 and permission bits 7:4 take the written value, bit 0 reads 0, and divider, flags, enables, compares and count read 0. Bus writes during those 4 cycles are ignored.
- R4: A compare flag (bit 0 for A, bit 1 for B) sets in the cycle the count steps onto that channel's compare value. The counter keeps counting past the match.
- R5: If a flag clear and a new match for the same flag land in the same cycle, the flag ends up set.
- R6: Flags are sticky. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R7: `irq` is high exactly while some flag is set together with its enable bit.
- R8: The count holds while bit 0 is 0 or the source is 0. Source 2 counts only on `tick_slow` and source 3 counts only on `tick_ref`.
- R9: Clearing and then setting bit 0 resumes counting from the held value. Only a reset clears the count.
- R10: While `lp_active` is high, the count advances only if the permission bit chosen by `lp_kind` (0 stop, 1 doze, 2 wait, 3 debug) is set.
- R11: After a system reset every register reads 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_slow | input | 1 | Slow source tick strobe |
| tick_ref | input | 1 | Reference source tick strobe |
| lp_active | input | 1 | Low-power mode is in effect |
| lp_kind | input | 2 | Low-power mode code |
| irq | output | 1 | Interrupt request |

## Verification
A wrong divider phase or a wrong step gate shows as a count that is off by one or more at the count register, read a fixed number of cycles after the counter was enabled. A flag that sets on the wrong cycle, or that never sets, shows in the flag register one cycle early or late around a compare value placed a known distance ahead. A bad flag update shows on `irq` in the cycle after the enable register is written. A software reset that spares the wrong control bits, or that lasts the wrong number of cycles, shows in the control readback within 5 cycles of the write.

// File: rtl/ftmr_pkg.sv
package ftmr_pkg;

    localparam int DW       = 32;
    localparam int NCMP     = 2;
    localparam int AW       = 3;
    localparam int SWR_BIT  = 15;
    localparam int LP_N     = 4;

    typedef enum logic [AW-1:0] {
        A_CTRL  = 3'd0,
        A_DIV   = 3'd1,
        A_FLAG  = 3'd2,
        A_IEN   = 3'd3,
        A_CMPA  = 3'd4,
        A_CMPB  = 3'd5,
        A_COUNT = 3'd6,
        A_NONE  = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        SRC_OFF  = 2'd0,
        SRC_CLK  = 2'd1,
        SRC_SLOW = 2'd2,
        SRC_REF  = 2'd3
    } src_e;

    typedef struct packed {
        logic [LP_N-1:0] lp_run;
        src_e            src;
        logic            en;
    } ctrl_t;

    function automatic logic pick_tick(src_e s, logic t_slow, logic t_ref);
        case (s)
            SRC_CLK:  return 1'b1;
            SRC_SLOW: return t_slow;
            SRC_REF:  return t_ref;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic logic [DW-1:0] ctrl_word(ctrl_t c, logic busy);
        logic [DW-1:0] w;
        w = '0;
        w[0]       = c.en;
        w[2:1]     = c.src;
        w[7:4]     = c.lp_run;
        w[SWR_BIT] = busy;
        return w;
    endfunction

    function automatic ctrl_t ctrl_decode(logic [DW-1:0] w, logic keep_off);
        ctrl_t c;
        c.en     = keep_off ? 1'b0 : w[0];
        c.src    = src_e'(w[2:1]);
        c.lp_run = w[7:4];
        return c;
    endfunction

endpackage

// File: rtl/ftmr_prescale.sv
module ftmr_prescale #(
    parameter int PS_W = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            run,
    input  logic [PS_W-1:0] ratio_m1,
    output logic            step
);
    logic [PS_W-1:0] phase;

    assign step = run && (phase >= ratio_m1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase <= '0;
        end else if (run) begin
            phase <= step ? '0 : phase + PS_W'(1);
        end
    end
endmodule

// File: rtl/ftmr_counter.sv
module ftmr_counter #(
    parameter int CNT_W = 32,
    parameter int NCMP  = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic                       step,
    input  logic [NCMP-1:0][CNT_W-1:0] cmp,
    output logic [CNT_W-1:0]           count,
    output logic [NCMP-1:0]            match
);
    logic [CNT_W-1:0] nxt;

    assign nxt = count + CNT_W'(1);

    for (genvar ch = 0; ch < NCMP; ch++) begin : g_match
        assign match[ch] = step && !clr && (nxt == cmp[ch]);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (step) begin
            count <= nxt;
        end
    end
endmodule

// File: rtl/ftmr_regs.sv
module ftmr_regs
    import ftmr_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int PS_W    = 12,
    parameter int SWR_CYC = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_wr,
    input  logic [AW-1:0]              bus_addr,
    input  logic [DW-1:0]              bus_wdata,
    output logic [DW-1:0]              bus_rdata,
    input  logic [CNT_W-1:0]           count,
    input  logic [NCMP-1:0]            match,
    output ctrl_t                      ctrl,
    output logic [PS_W-1:0]            ratio_m1,
    output logic [NCMP-1:0][CNT_W-1:0] cmp,
    output logic [NCMP-1:0]            flags,
    output logic [NCMP-1:0]            ien,
    output logic                       swr_start,
    output logic                       swr_busy,
    output logic                       div_wr
);
    localparam int BC_W = $clog2(SWR_CYC + 1);

    logic [BC_W-1:0] busy_cnt;
    logic            wr_ok;
    logic            clr_all;
    reg_addr_e       a;
    logic [NCMP-1:0] w1c;
    logic            unused_wbits;

    assign unused_wbits = ^bus_wdata;
    assign a         = reg_addr_e'(bus_addr);
    assign swr_busy  = (busy_cnt != '0);
    assign wr_ok     = bus_wr && !swr_busy;
    assign swr_start = wr_ok && (a == A_CTRL) && bus_wdata[SWR_BIT];
    assign clr_all   = swr_start || swr_busy;
    assign div_wr    = wr_ok && (a == A_DIV);
    assign w1c       = (wr_ok && a == A_FLAG) ? bus_wdata[NCMP-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cnt <= '0;
        end else if (swr_start) begin
            busy_cnt <= BC_W'(SWR_CYC);
        end else if (swr_busy) begin
            busy_cnt <= busy_cnt - BC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_ok && a == A_CTRL) begin
            ctrl <= ctrl_decode(bus_wdata, swr_start);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            ratio_m1 <= '0;
            ien      <= '0;
            flags    <= '0;
        end else begin
            if (div_wr) begin
                ratio_m1 <= bus_wdata[PS_W-1:0];
            end
            if (wr_ok && a == A_IEN) begin
                ien <= bus_wdata[NCMP-1:0];
            end
            flags <= (flags & ~w1c) | match;
        end
    end

    for (genvar ch = 0; ch < NCMP; ch++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (rst || clr_all) begin
                cmp[ch] <= '0;
            end else if (wr_ok && bus_addr == AW'(int'(A_CMPA) + ch)) begin
                cmp[ch] <= bus_wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (a)
            A_CTRL:  bus_rdata = ctrl_word(ctrl, swr_busy);
            A_DIV:   bus_rdata = DW'(ratio_m1);
            A_FLAG:  bus_rdata = DW'(flags);
            A_IEN:   bus_rdata = DW'(ien);
            A_CMPA:  bus_rdata = DW'(cmp[0]);
            A_CMPB:  bus_rdata = DW'(cmp[1]);
            A_COUNT: bus_rdata = DW'(count);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ftmr_top.sv
module ftmr_top
    import ftmr_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int PS_W    = 12,
    parameter int SWR_CYC = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          tick_slow,
    input  logic          tick_ref,
    input  logic          lp_active,
    input  logic [1:0]    lp_kind,
    output logic          irq
);
    ctrl_t                      ctrl;
    logic [PS_W-1:0]            ratio_m1;
    logic [NCMP-1:0][CNT_W-1:0] cmp;
    logic [NCMP-1:0]            flags;
    logic [NCMP-1:0]            ien;
    logic [NCMP-1:0]            match;
    logic [CNT_W-1:0]           count;
    logic                       swr_start;
    logic                       swr_busy;
    logic                       div_wr;
    logic                       lp_ok;
    logic                       run;
    logic                       step;
    logic                       cnt_clr;

    assign lp_ok   = !lp_active || ctrl.lp_run[lp_kind];
    assign run     = ctrl.en && lp_ok && pick_tick(ctrl.src, tick_slow, tick_ref);
    assign cnt_clr = swr_start || swr_busy;
    assign irq     = |(flags & ien);

    ftmr_regs #(.CNT_W(CNT_W), .PS_W(PS_W), .SWR_CYC(SWR_CYC)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .count     (count),
        .match     (match),
        .ctrl      (ctrl),
        .ratio_m1  (ratio_m1),
        .cmp       (cmp),
        .flags     (flags),
        .ien       (ien),
        .swr_start (swr_start),
        .swr_busy  (swr_busy),
        .div_wr    (div_wr)
    );

    ftmr_prescale #(.PS_W(PS_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .clr      (cnt_clr || div_wr),
        .run      (run),
        .ratio_m1 (ratio_m1),
        .step     (step)
    );

    ftmr_counter #(.CNT_W(CNT_W), .NCMP(NCMP)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (cnt_clr),
        .step  (step),
        .cmp   (cmp),
        .count (count),
        .match (match)
    );
endmodule

// File: rtl/ftmr_top_chk.sv
module ftmr_top_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             irq,
    input logic             en,
    input logic             step,
    input logic             swr_start,
    input logic             swr_busy,
    input logic [CNT_W-1:0] count,
    input logic [1:0]       flags,
    input logic             bus_wr,
    input logic [2:0]       bus_addr,
    input logic [31:0]      bus_wdata
);
    AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        (step && !swr_start && !swr_busy) |=> (count == $past(count) + CNT_W'(1))); // R1

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!en && !swr_start && !swr_busy) |=> $stable(count)); // R8

    AST_SWR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        swr_start |=> (swr_busy && !en && count == '0 && flags == '0)); // R3

    AST_BUSY_NO_RUN: assert property (@(posedge clk) disable iff (rst)
        swr_busy |-> !en); // R3

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flags[0] && !swr_start && !swr_busy &&
         !(bus_wr && bus_addr == 3'd2 && bus_wdata[0])) |=> flags[0]); // R6

    AST_NO_FLAG_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        (flags == 2'b00) |-> !irq); // R7
endmodule

bind ftmr_top ftmr_top_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq       (irq),
    .en        (ctrl.en),
    .step      (step),
    .swr_start (swr_start),
    .swr_busy  (swr_busy),
    .count     (count),
    .flags     (flags),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
);

// File: tb/ftmr_top_test.sv
`timescale 1ns/1ps
module ftmr_top_test;
    localparam logic [2:0] RC = 3'd0, RD = 3'd1, RF = 3'd2, RI = 3'd3,
                           RA = 3'd4, RB = 3'd5, RN = 3'd6;
    localparam logic [1:0] S_OFF = 2'd0, S_CLK = 2'd1, S_SLOW = 2'd2, S_REF = 2'd3;

    logic        clk = 0, rst = 1, bus_wr = 0;
    logic [2:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic        tick_slow = 0, tick_ref = 0, lp_active = 0, irq;
    logic [1:0]  lp_kind = 0;
    int          checks = 0, errors = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    ftmr_top #(.CNT_W(8)) uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_slow(tick_slow),
        .tick_ref(tick_ref), .lp_active(lp_active), .lp_kind(lp_kind), .irq(irq)
    );

    function automatic logic [31:0] ctl(logic en, logic [1:0] src, logic [3:0] lp);
        return {24'd0, lp, 1'b0, src, en};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(posedge clk); @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] v);
        bus_addr = a; #0.5; v = bus_rdata;
    endtask

    task automatic rdchk(string tag, logic [2:0] a, logic [31:0] exp);
        logic [31:0] v;
        rd(a, v); chk(tag, v, exp);
    endtask

    task automatic do_swr();
        wr(RC, 32'h8000);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 7; i++) rdchk("R11 reg after reset", 3'(i), 0);
        chk("R11 irq after reset", {31'd0, irq}, 0);
    endtask

    task automatic t_count();
        do_swr(); wr(RD, 0); wr(RC, ctl(1, S_CLK, 0));
        repeat (10) @(negedge clk);
        rdchk("R1 count after 10 steps", RN, 10);
    endtask

    task automatic t_hold();
        wr(RC, ctl(0, S_CLK, 0));
        rdchk("R8 count at disable", RN, 11);
        repeat (5) @(negedge clk);
        rdchk("R8 count holds while disabled", RN, 11);
        wr(RC, ctl(1, S_CLK, 0));
        rdchk("R9 re-enable keeps count", RN, 11);
        repeat (3) @(negedge clk);
        rdchk("R9 resumes from held value", RN, 14);
    endtask

    task automatic t_prescale();
        do_swr(); wr(RD, 3); wr(RC, ctl(1, S_CLK, 0));
        repeat (20) @(negedge clk);
        rdchk("R2 divide by 4 over 20 ticks", RN, 5);
    endtask

    task automatic t_source();
        do_swr(); wr(RC, ctl(1, S_OFF, 0));
        repeat (8) @(negedge clk);
        rdchk("R8 source off holds", RN, 0);
        wr(RC, ctl(1, S_SLOW, 0));
        tick_slow = 1; repeat (3) @(negedge clk); tick_slow = 0;
        tick_ref = 1; repeat (4) @(negedge clk); tick_ref = 0;
        rdchk("R8 slow source counts only its ticks", RN, 3);
    endtask

    task automatic t_lowpower();
        do_swr(); lp_active = 1; lp_kind = 2;
        wr(RC, ctl(1, S_CLK, 4'b0010));
        repeat (6) @(negedge clk);
        rdchk("R10 wait mode without permission stalls", RN, 0);
        wr(RC, ctl(1, S_CLK, 4'b0100));
        repeat (6) @(negedge clk);
        rdchk("R10 wait mode with permission runs", RN, 6);
        lp_active = 0; lp_kind = 0;
    endtask

    task automatic t_compare();
        do_swr(); wr(RA, 7); wr(RC, ctl(1, S_CLK, 0));
        repeat (6) @(negedge clk);
        rdchk("R4 no flag before match", RF, 0);
        @(negedge clk);
        rdchk("R4 flag A on match", RF, 1);
        chk("R7 irq low with enable clear", {31'd0, irq}, 0);
        repeat (5) @(negedge clk);
        rdchk("R6 flag sticky", RF, 1);
        rdchk("R4 counter runs past match", RN, 12);
        wr(RI, 1);
        chk("R7 irq with flag A enabled", {31'd0, irq}, 1);
        wr(RI, 2);
        chk("R7 irq off when only B enabled", {31'd0, irq}, 0);
        wr(RI, 1);
        wr(RF, 2);
        rdchk("R6 write 0 keeps flag", RF, 1);
        wr(RF, 1);
        rdchk("R6 write 1 clears flag", RF, 0);
        chk("R7 irq drops after clear", {31'd0, irq}, 0);
    endtask

    task automatic t_setwins();
        do_swr(); wr(RB, 10); wr(RC, ctl(1, S_CLK, 0));
        repeat (9) @(negedge clk);
        wr(RF, 2);
        rdchk("R5 set wins over clear", RF, 2);
        wr(RI, 2);
        chk("R7 irq from flag B", {31'd0, irq}, 1);
        wr(RF, 2);
        rdchk("R6 flag B cleared", RF, 0);
    endtask

    task automatic t_swr();
        wr(RD, 5); wr(RI, 3); wr(RA, 9);
        wr(RC, ctl(1, S_REF, 4'b1010));
        wr(RC, 32'h8000 | ctl(1, S_REF, 4'b1010));
        rdchk("R3 busy, kept bits, run off", RC, 32'h80A6);
        wr(RI, 3);
        repeat (2) @(negedge clk);
        rdchk("R3 still busy at cycle 4", RC, 32'h80A6);
        @(negedge clk);
        rdchk("R3 self-clears after 4 cycles", RC, 32'h00A6);
        rdchk("R3 divider cleared", RD, 0);
        rdchk("R3 enables cleared, busy write ignored", RI, 0);
        rdchk("R3 compare cleared", RA, 0);
        rdchk("R3 count cleared", RN, 0);
        rdchk("R3 flags cleared", RF, 0);
    endtask

    task automatic t_wrap();
        do_swr(); wr(RC, ctl(1, S_CLK, 0));
        repeat (260) @(negedge clk);
        rdchk("R1 count wraps", RN, 4);
        rdchk("R4 both zero compares match at wrap", RF, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset(); t_count(); t_hold(); t_prescale(); t_source();
        t_lowpower(); t_compare(); t_setwins(); t_swr(); t_wrap();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule